// File: doc/BRIEF.md
# Predication redirection table

This block keeps sixteen programmable predication entries and answers, for any destination register of an integer or floating-point operation, which predicate mask applies to that operation and whether disabled elements are to be zeroed. Software loads an entry through a CSR-style write port. Each entry names a key register, the register file the key belongs to (integer or float), an integer register that holds the mask, and two flags: one inverts the mask, the other requests zeroing.

A lookup names an operation type and a destination register. The block finds the entry keyed to that register, if there is one. It drives the predicate register's number onto a combinational register-file read port and applies the inversion to the data that comes back. One cycle after the request it presents the registered mask and zeroing flag. A destination with no enabled entry gets an all-ones mask, so every element proceeds. The stored register is never modified: any inversion is applied only on the way out.

Top module: `pred_redirect`

## Requirements
- R1: A configuration word has bank at bit 13, zero at bit 12, inv at bit 11, file select at bit 10 (0 = integer, 1 = float), key register at bits 9..5 and predicate register at bits 4..0; `cfg_we` stores `cfg_wdata` into entry `cfg_idx` at the clock edge.
- R2: A lookup of a destination register with no enabled entry in the selected file returns a mask of all ones and a zeroing flag of 0.
- R3: A lookup that hits an enabled entry drives `rf_raddr` with that entry's predicate register in the request cycle, and returns the `rf_rdata` value as the mask.
- R4: When inv is set, the returned mask is the bitwise complement of the register contents, and the register itself is left unchanged (a later non-inverting lookup of it returns the original value).
- R5: `res_zero` equals the zero flag of the hit entry, and is 0 when no entry is hit.
- R6: An entry affects lookups only in the file named by its select bit; the same register number in the other file is unaffected.
- R7: When two enabled entries share key and file, the higher-numbered entry decides the result, regardless of the order in which they were written.
- R8: An entry written with bank = 1 is invalid and takes no part in any lookup; a lower-numbered valid entry with the same key then applies, and without one the mask is all ones.
- R9: `res_valid` is 1 exactly in the cycle after a cycle with `lk_req` high; back-to-back requests each give a result, and `res_mask` and `res_zero` hold their values while no request is made.
- R10: After reset all entries are invalid, `res_valid` is 0 and `res_mask` is 0.
- R11: Rewriting an entry replaces its earlier key; the old key's slot goes back to the next valid entry or to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 4 | Entry number to write |
| cfg_wdata | input | 14 | Entry contents |
| lk_req | input | 1 | Lookup request |
| lk_is_fp | input | 1 | Operation type: 1 = float, 0 = integer |
| lk_dst | input | 5 | Destination register of the operation |
| rf_raddr | output | 5 | Integer register-file read address |
| rf_rdata | input | 32 | Integer register-file read data (same cycle) |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_mask | output | 32 | Effective predicate mask |
| res_zero | output | 1 | Zero disabled elements |

## Verification
The bench aims at the priority between entries that share a key: a design that searched lowest-first, or that let the latest write win, would give the mask of the wrong register after an out-of-order pair of writes. It writes entries with bank set, on top of a valid one and on an unused key, because a design that still stored them as valid would redirect to a register that should be ignored. It checks inversion against a later plain read of the same register, since a design that inverted in place or forgot the complement would fail one of the two. It also separates integer and float keys with the same number, and checks that a rewritten entry frees its old key, which a design that cached slots only on write would leave stale.

// File: rtl/pred_redirect_pkg.sv
package pred_redirect_pkg;

  // register number width of one bank (32 registers)
  localparam int REG_IDX_W = 5;
  localparam int NUM_REGS  = 1 << REG_IDX_W;

  // one configuration word; field order is the software-visible layout
  typedef struct packed {
    logic                 bank;
    logic                 zero;
    logic                 inv;
    logic                 is_fp;
    logic [REG_IDX_W-1:0] key;
    logic [REG_IDX_W-1:0] pidx;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  // expanded per-register lookup state
  typedef struct packed {
    logic                 en;
    logic                 zero;
    logic                 inv;
    logic [REG_IDX_W-1:0] pidx;
  } slot_t;

endpackage

// File: rtl/pred_entry_store.sv
module pred_entry_store
  import pred_redirect_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [IDX_W-1:0]             idx,
  input  entry_t                       wdata,
  output entry_t [NUM_ENTRIES-1:0]     ent_o,
  output logic   [NUM_ENTRIES-1:0]     vld_o
);

  entry_t [NUM_ENTRIES-1:0] ent_q;
  logic   [NUM_ENTRIES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q <= '0;
      vld_q <= '0;
    end else if (we) begin
      ent_q[idx] <= wdata;
      // only bank 0 is implemented; bank 1 leaves the entry invalid
      vld_q[idx] <= ~wdata.bank;
    end
  end

  assign ent_o = ent_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/pred_slot_table.sv
module pred_slot_table
  import pred_redirect_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int NUM_SLOTS = 2 * NUM_REGS
) (
  input  entry_t [NUM_ENTRIES-1:0] ent,
  input  logic   [NUM_ENTRIES-1:0] vld,
  output slot_t  [NUM_SLOTS-1:0]   slots
);

  // slot index = {is_fp, register}; later entries override earlier ones
  for (genvar f = 0; f < 2; f++) begin : g_file
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_comb begin
        slot_t s;
        s = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (vld[e] && (ent[e].is_fp == f[0]) &&
              (ent[e].key == r[REG_IDX_W-1:0])) begin
            s.en   = 1'b1;
            s.zero = ent[e].zero;
            s.inv  = ent[e].inv;
            s.pidx = ent[e].pidx;
          end
        end
        slots[f*NUM_REGS + r] = s;
      end
    end
  end

endmodule

// File: rtl/pred_mask_unit.sv
module pred_mask_unit
  import pred_redirect_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NUM_SLOTS = 2 * NUM_REGS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  slot_t [NUM_SLOTS-1:0] slots,
  input  logic                  lk_req,
  input  logic                  lk_is_fp,
  input  logic [REG_IDX_W-1:0]  lk_dst,
  output logic [REG_IDX_W-1:0]  rf_raddr,
  input  logic [XLEN-1:0]       rf_rdata,
  output logic                  res_valid,
  output logic [XLEN-1:0]       res_mask,
  output logic                  res_zero
);

  slot_t           sel;
  logic [XLEN-1:0] mask_c;
  logic            zero_c;

  always_comb begin
    sel      = slots[{lk_is_fp, lk_dst}];
    rf_raddr = sel.en ? sel.pidx : '0;
    if (!sel.en)       mask_c = '1;
    else if (sel.inv)  mask_c = ~rf_rdata;
    else               mask_c = rf_rdata;
    zero_c = sel.en & sel.zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_mask  <= '0;
      res_zero  <= 1'b0;
    end else begin
      res_valid <= lk_req;
      if (lk_req) begin
        res_mask <= mask_c;
        res_zero <= zero_c;
      end
    end
  end

endmodule

// File: rtl/pred_redirect.sv
module pred_redirect
  import pred_redirect_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [ENTRY_W-1:0]   cfg_wdata,
  input  logic                 lk_req,
  input  logic                 lk_is_fp,
  input  logic [REG_IDX_W-1:0] lk_dst,
  output logic [REG_IDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]      rf_rdata,
  output logic                 res_valid,
  output logic [XLEN-1:0]      res_mask,
  output logic                 res_zero
);

  entry_t [NUM_ENTRIES-1:0] ent;
  logic   [NUM_ENTRIES-1:0] vld;
  slot_t  [2*NUM_REGS-1:0]  slots;

  pred_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .wdata (entry_t'(cfg_wdata)),
    .ent_o (ent),
    .vld_o (vld)
  );

  pred_slot_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .ent   (ent),
    .vld   (vld),
    .slots (slots)
  );

  pred_mask_unit #(.XLEN(XLEN)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .slots     (slots),
    .lk_req    (lk_req),
    .lk_is_fp  (lk_is_fp),
    .lk_dst    (lk_dst),
    .rf_raddr  (rf_raddr),
    .rf_rdata  (rf_rdata),
    .res_valid (res_valid),
    .res_mask  (res_mask),
    .res_zero  (res_zero)
  );

endmodule

// File: rtl/pred_redirect_chk.sv
module pred_redirect_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic            lk_req,
  input logic [XLEN-1:0] rf_rdata,
  input logic            res_valid,
  input logic [XLEN-1:0] res_mask,
  input logic            res_zero
);

  logic any_written;

  always_ff @(posedge clk) begin
    if (rst)         any_written <= 1'b0;
    else if (cfg_we) any_written <= 1'b1;
  end

  // R9
  req_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> res_valid);

  // R9
  idle_gives_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !res_valid);

  // R9
  idle_holds_result_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> ($stable(res_mask) && $stable(res_zero)));

  // R2
  empty_table_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !any_written) |=> (res_mask == '1 && !res_zero));

  // R4
  mask_source_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (res_mask == $past(rf_rdata) || res_mask == ~$past(rf_rdata) ||
                res_mask == '1));

endmodule

bind pred_redirect pred_redirect_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .lk_req    (lk_req),
  .rf_rdata  (rf_rdata),
  .res_valid (res_valid),
  .res_mask  (res_mask),
  .res_zero  (res_zero)
);

// File: tb/pred_redirect_tb.sv
module pred_redirect_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [13:0] cfg_wdata;
  logic        lk_req;
  logic        lk_is_fp;
  logic [4:0]  lk_dst;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        res_valid;
  logic [31:0] res_mask;
  logic        res_zero;

  logic [31:0] rf [32];
  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata = rf[rf_raddr];

  pred_redirect u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .lk_req(lk_req), .lk_is_fp(lk_is_fp),
    .lk_dst(lk_dst), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .res_valid(res_valid), .res_mask(res_mask), .res_zero(res_zero)
  );

  function automatic logic [13:0] mk(input logic bank, zero, inv, fp,
                                     input logic [4:0] key, pidx);
    return {bank, zero, inv, fp, key, pidx};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [13:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input string tag, input logic fp, input logic [4:0] dst,
                      input logic [31:0] exp_mask, input logic exp_zero);
    @(negedge clk);
    lk_req = 1'b1; lk_is_fp = fp; lk_dst = dst;
    @(negedge clk);
    lk_req = 1'b0;
    chk({tag, " R9 valid"}, 32'(res_valid), 32'd1);
    chk({tag, " mask"}, res_mask, exp_mask);
    chk({tag, " R5 zero"}, 32'(res_zero), 32'(exp_zero));
  endtask

  task automatic look_raddr(input string tag, input logic fp,
                            input logic [4:0] dst, input logic [4:0] exp_a);
    @(negedge clk);
    lk_req = 1'b1; lk_is_fp = fp; lk_dst = dst;
    #1 chk(tag, 32'(rf_raddr), 32'(exp_a));
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 valid after reset", 32'(res_valid), 32'd0);
    chk("R10 mask after reset", res_mask, 32'd0);
    look("R2 R10 empty int 3", 1'b0, 5'd3, ONES, 1'b0);
    look("R2 empty fp 31", 1'b1, 5'd31, ONES, 1'b0);
  endtask

  task automatic t_basic;
    wr(4'd0, mk(0, 1, 0, 0, 5'd3, 5'd7));
    look_raddr("R3 raddr int 3", 1'b0, 5'd3, 5'd7);
    look("R1 R3 int 3 via r7", 1'b0, 5'd3, 32'hA5A5_0F0F, 1'b1);
    look("R6 fp 3 untouched", 1'b1, 5'd3, ONES, 1'b0);
  endtask

  task automatic t_invert;
    wr(4'd1, mk(0, 0, 1, 1, 5'd3, 5'd9));
    look("R4 R6 fp 3 inverted r9", 1'b1, 5'd3, ~32'h1234_5678, 1'b0);
    look("R6 int 3 still r7", 1'b0, 5'd3, 32'hA5A5_0F0F, 1'b1);
    wr(4'd3, mk(0, 0, 0, 0, 5'd10, 5'd9));
    look("R4 r9 unchanged", 1'b0, 5'd10, 32'h1234_5678, 1'b0);
  endtask

  task automatic t_priority;
    wr(4'd5, mk(0, 0, 0, 0, 5'd3, 5'd11));
    look("R7 entry5 over entry0", 1'b0, 5'd3, 32'hDEAD_BEEF, 1'b0);
    wr(4'd2, mk(0, 1, 0, 0, 5'd3, 5'd12));
    look("R7 later write lower idx loses", 1'b0, 5'd3, 32'hDEAD_BEEF, 1'b0);
  endtask

  task automatic t_bank;
    wr(4'd5, mk(1, 0, 0, 0, 5'd3, 5'd11));
    look("R8 bank1 drops entry5", 1'b0, 5'd3, 32'h0000_FFFF, 1'b1);
    wr(4'd15, mk(1, 1, 1, 0, 5'd20, 5'd11));
    look("R8 bank1 unused key", 1'b0, 5'd20, ONES, 1'b0);
  endtask

  task automatic t_rewrite;
    wr(4'd2, mk(0, 0, 0, 0, 5'd4, 5'd12));
    look("R11 old key back to entry0", 1'b0, 5'd3, 32'hA5A5_0F0F, 1'b1);
    look("R11 new key int 4", 1'b0, 5'd4, 32'h0000_FFFF, 1'b0);
    wr(4'd0, mk(0, 0, 0, 1, 5'd8, 5'd7));
    look("R11 int 3 now empty", 1'b0, 5'd3, ONES, 1'b0);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    lk_req = 1'b1; lk_is_fp = 1'b0; lk_dst = 5'd4;
    @(negedge clk);
    chk("R9 b2b first", res_mask, 32'h0000_FFFF);
    lk_is_fp = 1'b1; lk_dst = 5'd3;
    @(negedge clk);
    lk_req = 1'b0;
    chk("R9 b2b second valid", 32'(res_valid), 32'd1);
    chk("R9 b2b second", res_mask, ~32'h1234_5678);
    @(negedge clk);
    chk("R9 idle valid low", 32'(res_valid), 32'd0);
    chk("R9 idle mask held", res_mask, ~32'h1234_5678);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h0101_0101 * i;
    rf[7]  = 32'hA5A5_0F0F;
    rf[9]  = 32'h1234_5678;
    rf[11] = 32'hDEAD_BEEF;
    rf[12] = 32'h0000_FFFF;
    rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    lk_req = 1'b0; lk_is_fp = 1'b0; lk_dst = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_invert();
    t_priority();
    t_bank();
    t_rewrite();
    t_pipeline();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule